// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the software-visible front of a single DMA channel that serves one attached peripheral controller. It holds four 32-bit words: a control/status word, a transfer address, a byte count and an address-extension word. A bus master reads and writes them with full-word accesses. The block does not move data. It records where a transfer stands, and it moves the address forward by the length of every transfer that the peripheral reports as done.

The control word drives two signals toward the peripheral: a DMA-enable level and a reset strobe one clock long. It also gates the peripheral's interrupt line onto the system interrupt output. Some control bits are read-only, and a fixed version code is always present in the top bits. Several written values get special treatment. A reset request fires the strobe. A drain request clears itself. A write of zero leaves the drain bit set instead.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the address, count and extension words read 0, and `sys_irq_out`, `dev_rst_pulse` and `dev_dma_en` are low.
- R2: `bus_addr[3:2]` selects the word: 0 = control, 1 = address, 2 = count, 3 = extension. The other address bits are ignored, so the window repeats every 16 bytes. `bus_rdata` shows the selected word combinationally, and a read changes no state.
- R3: A control write keeps the old stored values in the bits of mask 0xFE000007 and takes the written value in all other bits, and the result is then ORed with 0xA0000000.
- R4: A control write with bit 7 (reset request) set drives `dev_rst_pulse` high for exactly the one clock cycle after the write edge. The written value is stored unchanged apart from the R3 masking.
- R5: A control write with bit 7 clear and bit 6 (drain) set stores bit 6 as 0.
- R6: A control write of the value 0 stores bit 6 as 1.
- R7: `dev_dma_en` equals bit 9 of the stored control word. It changes only on a control write.
- R8: Any write to the address word sets control bit 26 (loaded). Control writes cannot clear bit 26; only reset clears it.
- R9: Control bit 0 (pending) takes the value of `dev_irq_in` at every clock edge.
- R10: `sys_irq_out` is high exactly while control bit 0 and control bit 4 (interrupt enable) are both set. It reacts in the same cycle that either bit changes.
- R11: On a clock edge with `xfer_valid` high, the address word increases by `xfer_len`, wrapping modulo 2^32. A write to the address word in the same cycle takes priority over the increment.
- R12: Writes to the count and extension words store all 32 written bits, and those words change on nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for a full 32-bit word |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected word, combinational |
| dev_irq_in | input | 1 | Interrupt level from the peripheral |
| xfer_valid | input | 1 | Peripheral finished a transfer this cycle |
| xfer_len | input | LEN_W | Byte length of that transfer |
| sys_irq_out | output | 1 | Gated interrupt to the system |
| dev_rst_pulse | output | 1 | One-cycle reset strobe to the peripheral |
| dev_dma_en | output | 1 | DMA-enable level to the peripheral |

## Verification
The hardest cases to reach are collisions in a single cycle. One is an address write landing on the same edge as a transfer completion. Another is a control write landing on the edge where the interrupt line toggles. A third is the address increment wrapping past 2^32. The stimulus builds each of these on purpose: it loads the address near the top of the range and then issues a write and a transfer in the same cycle. A behavioural model compares every output and the selected read word on every clock, so the order of priority in each collision is checked at the ports.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int WORD_W = 32;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_RST    = 7;
    localparam int B_DIR    = 8;
    localparam int B_EN     = 9;
    localparam int B_LOADED = 26;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_EXT  = 2'd3
    } reg_sel_e;

    localparam int NUM_WORDS = 4;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic              pulse;
    } csr_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] ext;
    } ptr_state_t;
endpackage

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
    import dma_chan_pkg::*;
#(
    parameter logic [WORD_W-1:0] VERSION = 32'hA000_0000,
    parameter logic [WORD_W-1:0] RO_MASK = 32'hFE00_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              addr_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              irq_in,
    output logic [WORD_W-1:0] ctl_q,
    output logic              rst_pulse
);
    csr_state_t st_d, st_q;
    logic [WORD_W-1:0] wval;

    always_comb begin
        wval = wdata;
        if (wdata[B_RST]) begin
            wval = wdata;
        end else if (wdata[B_DRAIN]) begin
            wval[B_DRAIN] = 1'b0;
        end else if (wdata == '0) begin
            wval[B_DRAIN] = 1'b1;
        end

        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl = (st_q.ctl & RO_MASK) | (wval & ~RO_MASK) | VERSION;
        end
        if (addr_wr) begin
            st_d.ctl[B_LOADED] = 1'b1;
        end
        st_d.ctl[B_PEND] = irq_in;
        st_d.pulse       = ctl_wr & wdata[B_RST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl   <= VERSION;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q     = st_q.ctl;
    assign rst_pulse = st_q.pulse;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rst_pulse) |-> $past(ctl_wr && wdata[B_RST])); // R4

    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[B_LOADED] |=> ctl_q[B_LOADED]); // R8

    AST_EN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(ctl_wr)) |-> $stable(ctl_q[B_EN])); // R7

    AST_VERSION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ((ctl_q & VERSION) == VERSION)); // R3
endmodule

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
    import dma_chan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic              cnt_wr,
    input  logic              ext_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              xfer_valid,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] cnt_q,
    output logic [WORD_W-1:0] ext_q
);
    localparam int PAD_W = WORD_W - LEN_W;

    ptr_state_t st_d, st_q;
    logic [WORD_W-1:0] len_ext;

    assign len_ext = {{PAD_W{1'b0}}, xfer_len};

    always_comb begin
        st_d = st_q;
        if (addr_wr) begin
            st_d.addr = wdata;
        end else if (xfer_valid) begin
            st_d.addr = st_q.addr + len_ext;
        end
        if (cnt_wr) st_d.cnt = wdata;
        if (ext_wr) st_d.ext = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;
    assign cnt_q  = st_q.cnt;
    assign ext_q  = st_q.ext;

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(xfer_valid && !addr_wr))
        |-> (addr_q == $past(addr_q) + {{PAD_W{1'b0}}, $past(xfer_len)})); // R11

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(cnt_wr)) |-> $stable(cnt_q)); // R12
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                LEN_W   = 16,
    parameter logic [WORD_W-1:0] VERSION = 32'hA000_0000,
    parameter logic [WORD_W-1:0] RO_MASK = 32'hFE00_0007
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              dev_irq_in,
    input  logic              xfer_valid,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              sys_irq_out,
    output logic              dev_rst_pulse,
    output logic              dev_dma_en
);
    reg_sel_e          sel;
    logic [NUM_WORDS-1:0] wr_sel;
    logic [WORD_W-1:0] ctl_q, addr_q, cnt_q, ext_q;

    assign sel = reg_sel_e'(bus_addr[3:2]);

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_wdec
        assign wr_sel[i] = bus_wr && (bus_addr[3:2] == i[1:0]);
    end

    dma_csr_unit #(
        .VERSION(VERSION),
        .RO_MASK(RO_MASK)
    ) csr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (wr_sel[SEL_CTL]),
        .addr_wr  (wr_sel[SEL_ADDR]),
        .wdata    (bus_wdata),
        .irq_in   (dev_irq_in),
        .ctl_q    (ctl_q),
        .rst_pulse(dev_rst_pulse)
    );

    dma_ptr_regs #(
        .LEN_W(LEN_W)
    ) ptr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_wr   (wr_sel[SEL_ADDR]),
        .cnt_wr    (wr_sel[SEL_CNT]),
        .ext_wr    (wr_sel[SEL_EXT]),
        .wdata     (bus_wdata),
        .xfer_valid(xfer_valid),
        .xfer_len  (xfer_len),
        .addr_q    (addr_q),
        .cnt_q     (cnt_q),
        .ext_q     (ext_q)
    );

    always_comb begin
        unique case (sel)
            SEL_CTL:  bus_rdata = ctl_q;
            SEL_ADDR: bus_rdata = addr_q;
            SEL_CNT:  bus_rdata = cnt_q;
            default:  bus_rdata = ext_q;
        endcase
    end

    assign sys_irq_out = ctl_q[B_PEND] & ctl_q[B_IEN];
    assign dev_dma_en  = ctl_q[B_EN];

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_IRQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && sys_irq_out) |-> $past(dev_irq_in)); // R10

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (ctl_q[B_PEND] == $past(dev_irq_in))); // R9
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;
    localparam logic [31:0] VER = 32'hA000_0000;
    localparam logic [31:0] RO  = 32'hFE00_0007;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic dev_irq_in = 1'b0;
    logic xfer_valid = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic sys_irq_out, dev_rst_pulse, dev_dma_en;

    always #10 clk = ~clk;

    dma_chan_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_irq_in(dev_irq_in),
        .xfer_valid(xfer_valid), .xfer_len(xfer_len), .sys_irq_out(sys_irq_out),
        .dev_rst_pulse(dev_rst_pulse), .dev_dma_en(dev_dma_en)
    );

    int vectors = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    logic [31:0] m_ctl = VER, m_addr = '0, m_cnt = '0, m_ext = '0;
    logic m_pulse = 1'b0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] v, rd;
        if (!rst_n) begin
            m_ctl = VER; m_addr = '0; m_cnt = '0; m_ext = '0; m_pulse = 1'b0;
        end else begin
            m_pulse = bus_wr && bus_addr[3:2] == 2'd0 && bus_wdata[7];
            if (bus_wr) begin
                case (bus_addr[3:2])
                    2'd0: begin
                        v = bus_wdata;
                        if (v[7]) v = v;
                        else if (v[6]) v[6] = 1'b0;
                        else if (v == 32'd0) v = 32'h40;
                        m_ctl = (m_ctl & RO) | (v & ~RO) | VER;
                    end
                    2'd1: begin m_addr = bus_wdata; m_ctl[26] = 1'b1; end
                    2'd2: m_cnt = bus_wdata;
                    default: m_ext = bus_wdata;
                endcase
            end
            if (xfer_valid && !(bus_wr && bus_addr[3:2] == 2'd1))
                m_addr = m_addr + 32'(xfer_len);
            m_ctl[0] = dev_irq_in;
        end
        #5;
        if (rst_n) begin
            case (bus_addr[3:2])
                2'd0: rd = m_ctl;
                2'd1: rd = m_addr;
                2'd2: rd = m_cnt;
                default: rd = m_ext;
            endcase
            check(cur_req, "rdata", bus_rdata, rd);
            check(cur_req == "R1" ? "R1" : "R10", "sys_irq_out", 32'(sys_irq_out), 32'(m_ctl[0] & m_ctl[4]));
            check(cur_req == "R1" ? "R1" : "R4", "dev_rst_pulse", 32'(dev_rst_pulse), 32'(m_pulse));
            check(cur_req == "R1" ? "R1" : "R7", "dev_dma_en", 32'(dev_dma_en), 32'(m_ctl[9]));
        end
    end

    task automatic step(bit wr, logic [ADDR_W-1:0] a, logic [31:0] d,
                        bit irq, bit xv, logic [LEN_W-1:0] len);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        dev_irq_in = irq; xfer_valid = xv; xfer_len = len;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d, bit irq = 1'b0);
        step(1'b1, a, d, irq, 1'b0, '0);
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, bit irq = 1'b0);
        step(1'b0, a, 32'd0, irq, 1'b0, '0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);

        cur_req = "R12";
        wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'h1234_5678); rd(8'h08); rd(8'h0C);

        cur_req = "R2";
        rd(8'h18); rd(8'h2C); rd(8'hF8); wr(8'h38, 32'h0BAD_F00D); rd(8'h08); rd(8'h00); rd(8'h00);

        cur_req = "R3";
        wr(8'h00, 32'hFFFF_FF38); rd(8'h00);
        wr(8'h00, 32'h0000_0010); rd(8'h00);

        cur_req = "R4";
        wr(8'h00, 32'h0000_00C0); rd(8'h00); rd(8'h00);
        wr(8'h00, 32'h0000_0080); wr(8'h00, 32'h0000_0080); rd(8'h00);

        cur_req = "R5";
        wr(8'h00, 32'h0000_0050); rd(8'h00);

        cur_req = "R6";
        wr(8'h00, 32'h0000_0000); rd(8'h00);

        cur_req = "R7";
        wr(8'h00, 32'h0000_0200); rd(8'h00); rd(8'h04); wr(8'h00, 32'h0000_0210); wr(8'h00, 32'h0000_0001); rd(8'h00);

        cur_req = "R8";
        wr(8'h04, 32'h0000_1000); rd(8'h00);
        wr(8'h00, 32'h0000_0000); rd(8'h00); wr(8'h00, 32'hFBFF_FFFF); rd(8'h00);

        cur_req = "R9";
        rd(8'h00, 1'b1); rd(8'h00, 1'b1); rd(8'h00, 1'b0); rd(8'h00, 1'b1);
        wr(8'h00, 32'h0000_0001, 1'b0); rd(8'h00, 1'b0);

        cur_req = "R10";
        wr(8'h00, 32'h0000_0200, 1'b1); rd(8'h00, 1'b1);
        wr(8'h00, 32'h0000_0010, 1'b1); rd(8'h00, 1'b1);
        rd(8'h00, 1'b0); rd(8'h00, 1'b1);
        wr(8'h00, 32'h0000_0200, 1'b1); rd(8'h00, 1'b1); rd(8'h00, 1'b0);

        cur_req = "R11";
        wr(8'h04, 32'h0000_0100);
        step(1'b0, 8'h04, 32'd0, 1'b0, 1'b1, 16'd4);
        step(1'b0, 8'h04, 32'd0, 1'b0, 1'b1, 16'd60);
        step(1'b0, 8'h04, 32'd0, 1'b0, 1'b0, 16'd99);
        step(1'b1, 8'h04, 32'hFFFF_FFF0, 1'b0, 1'b1, 16'd8);
        step(1'b0, 8'h04, 32'd0, 1'b0, 1'b1, 16'h0020);
        step(1'b0, 8'h04, 32'd0, 1'b0, 1'b1, 16'hFFFF);
        step(1'b1, 8'h08, 32'h0000_0007, 1'b0, 1'b1, 16'd2);
        rd(8'h04); rd(8'h08); rd(8'h0C);

        cur_req = "R12";
        step(1'b0, 8'h08, 32'd0, 1'b1, 1'b1, 16'd5);
        rd(8'h08); rd(8'h0C);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule